// File: doc/BRIEF.md
# Hash Engine Interrupt Controller

This block collects event pulses from a hash accelerator and turns them into two interrupt lines. The events are: a context has been loaded and the engine is ready for the next one, a partial hash result is ready after a suspend, the input data FIFO has room for the next 64-byte block, and a final result is ready. Each event sets a sticky status bit. Software reads the status bits through a small register interface and clears them by writing ones.

A per-source enable register and a global enable gate the main interrupt line. A second line, reserved for partial-hash results, ignores the per-source enables and is gated by the global enable alone. When a context-switch suspend lands on a final or outer hash, no partial result exists. The partial-hash event is then recorded as a result-ready event instead.

Top module: `hash_irq_ctrl`

## Requirements
- R1: After a synchronous reset the status bits, the enable bits, the global enable, both interrupt outputs and the read data are all zero.
- R2: A pulse on an event input sets its status bit, and the bit stays set until it is cleared. Bit positions are: ctx_load_evt bit 3, part_done_evt bit 2, fifo_room_evt bit 1, result_evt bit 0.
- R3: A write to address 0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R4: If an event arrives in the same cycle as a clear of its bit, the event wins and the bit stays set.
- R5: If part_done_evt arrives while suspend_req and final_hash are both 1, status bit 0 is set and bit 2 is not. If part_done_evt arrives without final_hash, bit 2 is set.
- R6: irq_main is 1 exactly one cycle after a cycle in which the global enable is 1 and at least one status bit is set together with its enable bit. It drops one cycle after that condition ends.
- R7: irq_part is 1 exactly one cycle after a cycle in which the global enable and status bit 2 are both 1. It does not depend on the enable register.
- R8: Address 1 holds the 4-bit enable register and address 2 holds the global enable in bit 0. Both can be written and read back. When reg_rd is 1, reg_rdata shows the addressed value on the next cycle and then holds it.
- R9: Address 3 reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_load_evt | input | 1 | Pulse: engine is ready for the next context |
| part_done_evt | input | 1 | Pulse: partial hash result is ready after a suspend |
| fifo_room_evt | input | 1 | Pulse: input FIFO has room for a 64-byte block |
| result_evt | input | 1 | Pulse: final result is ready |
| suspend_req | input | 1 | Context-switch suspend is in progress |
| final_hash | input | 1 | Current pass is a final or outer hash |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Registered read data |
| irq_main | output | 1 | Masked main interrupt |
| irq_part | output | 1 | Partial-hash interrupt, gated by the global enable only |

## Verification
Two situations are hard to reach from the ports. The first is an event that lands in the same cycle as a write-one-to-clear of its own bit. The second is a partial-hash event that arrives while both suspend_req and final_hash are high. Directed steps place each of these in a single chosen cycle. A long seeded random phase then mixes sparse event pulses, random suspend and final flags, writes and reads, so the same collisions also occur with the interrupts enabled and disabled in many combinations. Every interrupt output and every read result is compared with a bench-side model of the status and enable registers.

// File: rtl/hash_irq_pkg.sv
`timescale 1ns/1ps
package hash_irq_pkg;
  localparam int SRC_N   = 4;
  localparam int ADDR_W  = 2;
  // status and enable bit positions
  localparam int BIT_CTX  = 3;
  localparam int BIT_PART = 2;
  localparam int BIT_FIFO = 1;
  localparam int BIT_RES  = 0;
  // register addresses
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE = 2'd1;
  localparam logic [ADDR_W-1:0] A_GLOBAL = 2'd2;
  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/hash_irq_evmap.sv
`timescale 1ns/1ps
module hash_irq_evmap
  import hash_irq_pkg::*;
(
  input  logic     ctx_load_evt,
  input  logic     part_done_evt,
  input  logic     fifo_room_evt,
  input  logic     result_evt,
  input  logic     suspend_req,
  input  logic     final_hash,
  output src_vec_t set_vec
);
  logic part_as_result;

  // a suspend on a closing pass yields a complete result, not a partial one
  assign part_as_result = part_done_evt && suspend_req && final_hash;

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_CTX]  = ctx_load_evt;
    set_vec[BIT_PART] = part_done_evt && !part_as_result;
    set_vec[BIT_FIFO] = fifo_room_evt;
    set_vec[BIT_RES]  = result_evt || part_as_result;
  end
endmodule

// File: rtl/hash_irq_status.sv
`timescale 1ns/1ps
module hash_irq_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] status
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             status[i] <= 1'b0;
      else if (set_vec[i]) status[i] <= 1'b1;   // set beats clear
      else if (clr_vec[i]) status[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hash_irq_cfg.sv
`timescale 1ns/1ps
module hash_irq_cfg
  import hash_irq_pkg::*;
#(
  parameter int N  = SRC_N,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [N-1:0]  reg_wdata,
  input  logic [N-1:0]  status,
  output logic [N-1:0]  clr_vec,
  output logic [N-1:0]  enable,
  output logic          gie,
  output logic [N-1:0]  reg_rdata
);
  logic [N-1:0] rd_mux;

  assign clr_vec = (reg_wr && reg_addr == AW'(A_STATUS)) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      gie    <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == AW'(A_ENABLE)) enable <= reg_wdata;
      if (reg_addr == AW'(A_GLOBAL)) gie    <= reg_wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == AW'(A_STATUS))      rd_mux = status;
    else if (reg_addr == AW'(A_ENABLE)) rd_mux = enable;
    else if (reg_addr == AW'(A_GLOBAL)) rd_mux = N'(gie);
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/hash_irq_out.sv
`timescale 1ns/1ps
module hash_irq_out
  import hash_irq_pkg::*;
#(
  parameter int N = SRC_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] status,
  input  logic [N-1:0] enable,
  input  logic         gie,
  output logic         irq_main,
  output logic         irq_part
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_main <= 1'b0;
      irq_part <= 1'b0;
    end else begin
      irq_main <= gie && (|(status & enable));
      irq_part <= gie && status[BIT_PART];   // per-source mask bypassed
    end
  end
endmodule

// File: rtl/hash_irq_ctrl.sv
`timescale 1ns/1ps
module hash_irq_ctrl
  import hash_irq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctx_load_evt,
  input  logic              part_done_evt,
  input  logic              fifo_room_evt,
  input  logic              result_evt,
  input  logic              suspend_req,
  input  logic              final_hash,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [SRC_N-1:0]  reg_wdata,
  output logic [SRC_N-1:0]  reg_rdata,
  output logic              irq_main,
  output logic              irq_part
);
  src_vec_t set_vec, clr_vec, status_q, enable_q;
  logic     gie_q;

  hash_irq_evmap u_map (
    .ctx_load_evt (ctx_load_evt),
    .part_done_evt(part_done_evt),
    .fifo_room_evt(fifo_room_evt),
    .result_evt   (result_evt),
    .suspend_req  (suspend_req),
    .final_hash   (final_hash),
    .set_vec      (set_vec)
  );

  hash_irq_status #(.N(SRC_N)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .status (status_q)
  );

  hash_irq_cfg #(.N(SRC_N), .AW(AW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .status   (status_q),
    .clr_vec  (clr_vec),
    .enable   (enable_q),
    .gie      (gie_q),
    .reg_rdata(reg_rdata)
  );

  hash_irq_out #(.N(SRC_N)) u_out (
    .clk     (clk),
    .rst     (rst),
    .status  (status_q),
    .enable  (enable_q),
    .gie     (gie_q),
    .irq_main(irq_main),
    .irq_part(irq_part)
  );
endmodule

// File: rtl/hash_irq_ctrl_chk.sv
`timescale 1ns/1ps
module hash_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctx_load_evt,
  input logic       part_done_evt,
  input logic       fifo_room_evt,
  input logic       suspend_req,
  input logic       final_hash,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [3:0] reg_wdata,
  input logic [3:0] status_q,
  input logic [3:0] enable_q,
  input logic       gie_q,
  input logic       irq_main,
  input logic       irq_part
);
  // R2
  ctx_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ctx_load_evt |=> status_q[3]);

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[3] && !ctx_load_evt) |=> !status_q[3]);

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[1] && fifo_room_evt) |=> status_q[1]);

  // R5
  remap_result_chk: assert property (@(posedge clk) disable iff (rst)
    (part_done_evt && suspend_req && final_hash) |=> status_q[0]);

  // R5
  remap_no_part_chk: assert property (@(posedge clk) disable iff (rst)
    (part_done_evt && suspend_req && final_hash && !status_q[2]) |=> !status_q[2]);

  // R6
  main_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_main == $past(gie_q && (|(status_q & enable_q))));

  // R7
  part_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_part == $past(gie_q && status_q[2]));

  // R9
  hole_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd3) |=> ($stable(enable_q) && $stable(gie_q)));
endmodule

bind hash_irq_ctrl hash_irq_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ctx_load_evt (ctx_load_evt),
  .part_done_evt(part_done_evt),
  .fifo_room_evt(fifo_room_evt),
  .suspend_req  (suspend_req),
  .final_hash   (final_hash),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .status_q     (status_q),
  .enable_q     (enable_q),
  .gie_q        (gie_q),
  .irq_main     (irq_main),
  .irq_part     (irq_part)
);

// File: tb/tb_hash_irq_ctrl.sv
`timescale 1ns/1ps
module tb_hash_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       ctx_load_evt, part_done_evt, fifo_room_evt, result_evt;
  logic       suspend_req, final_hash, reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [3:0] reg_wdata, reg_rdata;
  logic       irq_main, irq_part;

  int checks = 0;
  int fails  = 0;

  // bench-side model
  logic [3:0] m_st = '0, m_en = '0;
  logic       m_gie = 1'b0;
  logic       x_main = 1'b0, x_part = 1'b0;
  logic [3:0] x_rd = '0;

  always #4 clk = ~clk;   // 125 MHz

  hash_irq_ctrl dut (
    .clk(clk), .rst(rst),
    .ctx_load_evt(ctx_load_evt), .part_done_evt(part_done_evt),
    .fifo_room_evt(fifo_room_evt), .result_evt(result_evt),
    .suspend_req(suspend_req), .final_hash(final_hash),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_main(irq_main), .irq_part(irq_part)
  );

  // events {ctx,part,fifo,res} -> status set vector per R2/R5
  function automatic logic [3:0] set_of(logic [3:0] ev, logic sus, logic fin);
    logic [3:0] s;
    s = ev;
    if (ev[2] && sus && fin) begin
      s[2] = 1'b0;
      s[0] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [3:0] read_of(logic [1:0] a);
    case (a)
      2'd0:    return m_st;
      2'd1:    return m_en;
      2'd2:    return {3'b000, m_gie};
      default: return 4'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, model after posedge, compare at next negedge
  task automatic cyc(logic [3:0] ev, logic sus, logic fin, logic wr, logic rd,
                     logic [1:0] a, logic [3:0] wd, string tag);
    logic [3:0] clr;
    {ctx_load_evt, part_done_evt, fifo_room_evt, result_evt} = ev;
    suspend_req = sus; final_hash = fin;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    @(posedge clk); #1;
    x_main = m_gie && (|(m_st & m_en));
    x_part = m_gie && m_st[2];
    if (rd) x_rd = read_of(a);
    clr = (wr && a == 2'd0) ? wd : 4'h0;
    m_st = (m_st & ~clr) | set_of(ev, sus, fin);
    if (wr && a == 2'd1) m_en = wd;
    if (wr && a == 2'd2) m_gie = wd[0];
    @(negedge clk);
    check("R6 irq_main", {3'b0, irq_main}, {3'b0, x_main});
    check("R7 irq_part", {3'b0, irq_part}, {3'b0, x_part});
    check(tag, reg_rdata, x_rd);
  endtask

  task automatic idle(string tag);
    cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'h0, tag);
  endtask

  task automatic rd_reg(logic [1:0] a, string tag);
    cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, a, 4'h0, tag);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [3:0] d, string tag);
    cyc(4'h0, 1'b0, 1'b0, 1'b1, 1'b0, a, d, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1;
    {ctx_load_evt, part_done_evt, fifo_room_evt, result_evt} = '0;
    suspend_req = 0; final_hash = 0; reg_wr = 0; reg_rd = 0;
    reg_addr = 0; reg_wdata = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // r1_ reset state at the ports
    check("R1 irq_main", {3'b0, irq_main}, 4'h0);
    check("R1 irq_part", {3'b0, irq_part}, 4'h0);
    check("R1 rdata", reg_rdata, 4'h0);
    rd_reg(2'd0, "R1 status");
    rd_reg(2'd1, "R1 enable");
    rd_reg(2'd2, "R1 global");

    // R8 enable and global enable write and readback
    wr_reg(2'd2, 4'h1, "R8 wr");
    wr_reg(2'd1, 4'b0001, "R8 wr");
    rd_reg(2'd1, "R8 enable readback");
    rd_reg(2'd2, "R8 global readback");
    idle("R8 hold");

    // R2 context event is sticky; masked so irq_main stays low
    cyc(4'b1000, 0, 0, 0, 0, 2'd0, 4'h0, "R2 pulse");
    idle("R2");
    rd_reg(2'd0, "R2 sticky ctx");

    // R7 partial event raises irq_part although its enable is 0
    cyc(4'b0100, 0, 0, 0, 0, 2'd0, 4'h0, "R7 pulse");
    idle("R7");
    rd_reg(2'd0, "R7 status");

    // R3 clear only bit 3
    wr_reg(2'd0, 4'b1000, "R3 w1c");
    rd_reg(2'd0, "R3 partial clear");

    // R4 set in same cycle as its clear
    cyc(4'b0010, 0, 0, 1, 0, 2'd0, 4'b0010, "R4 collide");
    rd_reg(2'd0, "R4 set wins");

    // R5 remap under suspend + final
    wr_reg(2'd0, 4'hF, "R5 clear all");
    cyc(4'b0100, 1, 1, 0, 0, 2'd0, 4'h0, "R5 remap");
    rd_reg(2'd0, "R5 result not partial");
    idle("R5");
    cyc(4'b0100, 1, 0, 0, 0, 2'd0, 4'h0, "R5 no final");
    rd_reg(2'd0, "R5 partial kept");

    // R9 hole address
    wr_reg(2'd3, 4'hF, "R9 wr hole");
    rd_reg(2'd3, "R9 hole reads zero");
    rd_reg(2'd1, "R9 enable untouched");
    rd_reg(2'd2, "R9 global untouched");

    // R6 global disable drops both lines
    wr_reg(2'd2, 4'h0, "R6 gie off");
    idle("R6");
    idle("R6");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] ev;
      ev = 4'h0;
      for (int b = 0; b < 4; b++) ev[b] = ($urandom % 8) == 0;
      cyc(ev, ($urandom % 4) == 0, ($urandom % 2) == 0,
          ($urandom % 6) == 0, ($urandom % 2) == 0,
          2'($urandom), 4'($urandom), "R8 random read");
    end

    summary();
    $finish;
  end
endmodule